// File: doc/BRIEF.md
# Soft-Start Fault Supervisor

This block is the digital supervisor of a power controller with several outputs. It runs a soft-start ramp code that the output references follow. After an over-current it inhibits the outputs and retries. Repeated or severe faults end in a latched shutdown. Its inputs are comparator flags: an over-voltage and an over-current flag for the main switching output, an under-voltage flag for each of three linear outputs, a good flag for each of the four outputs, and a low-threshold flag that is watched while reset is held.

A digital counter stands in for the soft-start capacitor. It climbs one code per enable tick up to its full-scale code. It falls by a larger step per tick when a retry discharges it. An over-current that arrives during the climb inhibits the outputs at once, but the ramp still finishes charging to full scale before it discharges. When the ramp reaches zero, a new attempt starts by itself. Each retry counts as one event. A set number of events, or any over-voltage, latches the fault. Only reset clears the latch.

Top module: `ss_fault_supervisor`

## Requirements
- R1: After reset the ramp code is 0 and rises by exactly one code on each clock with `tick_i` high; it holds its value on clocks with `tick_i` low.
- R2: Soft-start is complete when the ramp sits at full scale (all ones) with no pending event. `pgood_o` is 1 only when soft-start is complete, the outputs are not inhibited and all four bits of `good_i` are 1.
- R3: `ov_i` sampled high sets `fault_o` and `lower_on_o` on that clock edge, with no counting. Both stay high until reset.
- R4: An over-current (`oc_i` high) raises `inhibit_o` on the next edge and counts one event. If the ramp is still rising, it keeps climbing to full scale and only then discharges.
- R5: A discharging ramp falls by DIS_STEP per tick and saturates at 0. On the tick that reaches 0, `inhibit_o` drops and a new rise begins from 0.
- R6: `luv_i` has no effect until soft-start is complete. Once it is complete, any `luv_i` bit high counts as an event, the same as an over-current.
- R7: The FAULT_LIMIT-th event sets `fault_o`. A set fault holds `inhibit_o` high, holds `pgood_o` low, discharges the ramp to 0 and parks it there, and ignores further events. `lower_on_o` stays 0 for a fault caused by events.
- R8: Only reset clears the fault latch and the event count.
- R9: While `rst_ni` is low, `lower_on_o` follows `early_ov_i`. After reset is released, `early_ov_i` has no effect.
- R10: An event condition held over several cycles counts once per retry, because new events are ignored while a retry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Ramp step enable |
| ov_i | input | 1 | Main output over-voltage flag |
| oc_i | input | 1 | Main output over-current flag |
| luv_i | input | 3 | Linear output under-voltage flags |
| good_i | input | 4 | Per-output above-under-voltage flags |
| early_ov_i | input | 1 | Main output above low threshold (used while in reset) |
| ramp_o | output | RAMP_W | Soft-start ramp code |
| inhibit_o | output | 1 | Disable all outputs |
| lower_on_o | output | 1 | Force lower switch on |
| pgood_o | output | 1 | Power good |
| fault_o | output | 1 | Latched fault pin |

## Verification
The bench builds the block with a 4-bit ramp, a discharge step of 4 and a limit of three events. With these values a full rise takes 15 ticks and a discharge takes 4. The whole retry history can then be stepped through one cycle at a time: a masked and an unmasked linear under-voltage, an over-current during the climb that carries the ramp to full scale, a held over-current that counts only once, the third event that latches, and an over-voltage taken mid-ramp. Every expected ramp code is computed from the step sizes.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [1:0] {
    SS_RISE  = 2'd0,
    SS_DONE  = 2'd1,
    SS_DISCH = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ssf_ramp.sv
module ssf_ramp
  import ssf_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int DIS_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic              fault_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              done_o,
  output logic              restart_o
);
  localparam logic [RAMP_W-1:0] RampMax = {RAMP_W{1'b1}};
  localparam logic [RAMP_W-1:0] Step    = RAMP_W'(DIS_STEP);

  ss_state_e         st_q;
  logic [RAMP_W-1:0] ramp_q;

  assign restart_o = (st_q == SS_DISCH) && tick_i && (ramp_q <= Step) && !fault_i;
  assign done_o    = (st_q == SS_DONE);
  assign ramp_o    = ramp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SS_RISE;
      ramp_q <= '0;
    end else begin
      unique case (st_q)
        SS_RISE: begin
          if (fault_i) st_q <= SS_DISCH;
          else if (tick_i) begin
            if (ramp_q == RampMax) st_q <= pend_i ? SS_DISCH : SS_DONE;
            else ramp_q <= ramp_q + 1'b1;
          end
        end
        SS_DONE: begin
          if (pend_i || fault_i) st_q <= SS_DISCH;
        end
        SS_DISCH: begin
          if (tick_i) begin
            if (ramp_q <= Step) begin
              ramp_q <= '0;
              if (!fault_i) st_q <= SS_RISE;
            end else ramp_q <= ramp_q - Step;
          end
        end
        default: st_q <= SS_RISE;
      endcase
    end
  end

  assert_rise_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SS_RISE && tick_i && !fault_i && ramp_q != RampMax) |=> ramp_q == $past(ramp_q) + 1'b1);
  assert_hold_no_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && st_q != SS_DISCH) |=> $stable(ramp_q));
  assert_disch_falls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SS_DISCH) |=> ramp_q <= $past(ramp_q));
  assert_done_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SS_DONE) |-> ramp_q == RampMax);
endmodule

// File: rtl/ssf_tracker.sv
module ssf_tracker #(
  parameter int NUM_LIN     = 3,
  parameter int FAULT_LIMIT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ov_i,
  input  logic               oc_i,
  input  logic [NUM_LIN-1:0] luv_i,
  input  logic               done_i,
  input  logic               restart_i,
  output logic               pend_o,
  output logic               fault_o,
  output logic               ov_fault_o
);
  localparam int CNT_W = $clog2(FAULT_LIMIT + 1);
  localparam logic [CNT_W-1:0] Limit = CNT_W'(FAULT_LIMIT);

  logic             pend_q, fault_q, ovf_q, evt;
  logic [CNT_W-1:0] cnt_q;

  // linear under-voltage only counts once soft-start is complete
  assign evt = (oc_i || (|luv_i && done_i)) && !pend_q && !fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      fault_q <= 1'b0;
      ovf_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (ov_i) begin
        fault_q <= 1'b1;
        ovf_q   <= 1'b1;
      end
      if (evt) begin
        pend_q <= 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q + 1'b1 == Limit) fault_q <= 1'b1;
      end else if (restart_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend_o     = pend_q;
  assign fault_o    = fault_q;
  assign ov_fault_o = ovf_q;

  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q);
  assert_ov_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_i |=> (fault_q && ovf_q));
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Limit);
  assert_one_per_retry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ss_fault_supervisor.sv
module ss_fault_supervisor #(
  parameter int RAMP_W      = 8,
  parameter int DIS_STEP    = 4,
  parameter int FAULT_LIMIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ov_i,
  input  logic              oc_i,
  input  logic [2:0]        luv_i,
  input  logic [3:0]        good_i,
  input  logic              early_ov_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              inhibit_o,
  output logic              lower_on_o,
  output logic              pgood_o,
  output logic              fault_o
);
  logic pend, fault, ov_fault, done, restart;

  ssf_ramp #(.RAMP_W(RAMP_W), .DIS_STEP(DIS_STEP)) u_ramp (
    .clk_i, .rst_ni, .tick_i,
    .pend_i(pend), .fault_i(fault),
    .ramp_o, .done_o(done), .restart_o(restart)
  );

  ssf_tracker #(.NUM_LIN(3), .FAULT_LIMIT(FAULT_LIMIT)) u_trk (
    .clk_i, .rst_ni, .ov_i, .oc_i, .luv_i,
    .done_i(done), .restart_i(restart),
    .pend_o(pend), .fault_o(fault), .ov_fault_o(ov_fault)
  );

  assign inhibit_o  = pend || fault;
  assign fault_o    = fault;
  assign pgood_o    = done && !inhibit_o && (&good_i);
  // pre-reset crowbar path is combinational on the reset pin
  assign lower_on_o = ov_fault || (!rst_ni && early_ov_i);

  assert_pgood_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (!inhibit_o && !fault_o && (&good_i)));
  assert_fault_inhibits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> inhibit_o);
endmodule

// File: tb/ss_fault_supervisor_test.sv
`timescale 1ns/1ps
module ss_fault_supervisor_test;
  localparam int RW = 4;
  localparam int STEP = 4;
  localparam int FULL = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1, ov = 1'b0, oc = 1'b0, early_ov = 1'b0;
  logic [2:0] luv = '0;
  logic [3:0] good = 4'hF;
  logic [RW-1:0] ramp;
  logic inhibit, lower_on, pgood, fault;
  int checks = 0, errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  ss_fault_supervisor #(.RAMP_W(RW), .DIS_STEP(STEP), .FAULT_LIMIT(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .ov_i(ov), .oc_i(oc),
    .luv_i(luv), .good_i(good), .early_ov_i(early_ov),
    .ramp_o(ramp), .inhibit_o(inhibit), .lower_on_o(lower_on),
    .pgood_o(pgood), .fault_o(fault));

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int r, input int inh, input int pg, input int f, input int lo);
    chk(req, "ramp", int'(ramp), r);
    chk(req, "inhibit", int'(inhibit), inh);
    chk(req, "pgood", int'(pgood), pg);
    chk(req, "fault", int'(fault), f);
    chk(req, "lower_on", int'(lower_on), lo);
  endtask

  initial begin
    #200000;
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: lower switch follows the early flag while in reset
    early_ov = 1'b1;
    #7;
    chk("R9", "lower_on in reset", int'(lower_on), 1);
    early_ov = 1'b0;
    #1;
    chk_out("R1", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    early_ov = 1'b1;  // R9: ignored once out of reset
    cyc(3);
    chk_out("R9", 3, 0, 0, 0, 0);
    early_ov = 1'b0;
    tick = 1'b0;
    cyc(4);
    chk("R1", "ramp held without tick", int'(ramp), 3);
    tick = 1'b1;
    luv = 3'b111;  // R6: masked during the rise
    cyc(2);
    chk("R6", "luv masked inhibit", int'(inhibit), 0);
    chk("R6", "ramp keeps rising", int'(ramp), 5);
    luv = '0;
    cyc(FULL - 5);
    chk("R2", "pgood before complete", int'(pgood), 0);
    chk("R1", "ramp at full", int'(ramp), FULL);
    cyc(1);
    chk("R2", "pgood after complete", int'(pgood), 1);
    good = 4'b1110;
    #1;
    chk("R2", "pgood one flag low", int'(pgood), 0);
    good = 4'hF;
    // R6: post-soft-start under-voltage counts as event 1
    luv = 3'b010;
    cyc(1);
    luv = '0;
    chk_out("R6", FULL, 1, 0, 0, 0);
    cyc(1);
    chk("R5", "ramp on discharge entry", int'(ramp), FULL);
    cyc(1);
    chk("R5", "first step down", int'(ramp), FULL - STEP);
    cyc(2);
    chk("R5", "third step down", int'(ramp), FULL - 3 * STEP);
    cyc(1);
    chk_out("R5", 0, 0, 0, 0, 0);
    cyc(1);
    chk("R5", "restart rise", int'(ramp), 1);
    // R4/R10: over-current held three cycles during the rise, event 2
    oc = 1'b1;
    cyc(3);
    oc = 1'b0;
    chk("R4", "inhibit after oc", int'(inhibit), 1);
    chk("R4", "ramp continues", int'(ramp), 4);
    cyc(FULL - 4);
    chk("R4", "ramp reaches full while inhibited", int'(ramp), FULL);
    chk("R4", "still inhibited", int'(inhibit), 1);
    cyc(1);
    chk("R4", "discharge after full", int'(ramp), FULL);
    cyc(4);
    chk_out("R10", 0, 0, 0, 0, 0);
    cyc(FULL + 1);
    chk("R2", "pgood second completion", int'(pgood), 1);
    // R7: third event latches
    oc = 1'b1;
    cyc(1);
    oc = 1'b0;
    chk_out("R7", FULL, 1, 0, 1, 0);
    cyc(5);
    chk_out("R7", 0, 1, 0, 1, 0);
    cyc(5);
    oc = 1'b1;
    luv = 3'b001;
    cyc(2);
    oc = 1'b0;
    luv = '0;
    chk_out("R7", 0, 1, 0, 1, 0);
    // R8: reset clears
    rst_ni = 1'b0;
    #1;
    chk_out("R8", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(6);
    chk("R8", "rise after reset", int'(ramp), 6);
    // R3: over-voltage latches at once
    ov = 1'b1;
    cyc(1);
    ov = 1'b0;
    chk_out("R3", 7, 1, 0, 1, 1);
    cyc(1);
    chk("R3", "ramp on discharge entry", int'(ramp), 7);
    cyc(1);
    chk("R5", "step down", int'(ramp), 3);
    cyc(1);
    chk_out("R3", 0, 1, 0, 1, 1);
    cyc(20);
    chk_out("R3", 0, 1, 0, 1, 1);
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule